// File: doc/BRIEF.md
# Parallel Bus Target Interface

This block is the target side of a 32-bit parallel bus on which address and data share one set of lines and a single 4-bit field carries the cycle command in the address phase and active-low byte lanes in the data phases. It watches for the start of a cycle, which is the cycle-start line going low. It decodes the first clock as the address phase and claims four kinds of cycle: I/O read, I/O write, configuration read and configuration write. Once it has claimed a cycle it drives its claim line and its ready line for each data phase until the initiator signals the last phase.

On the local side a simple register port receives a byte offset, a space flag (configuration or I/O), write and read strobes with byte enables and write data, and it returns read data. A local-ready input lets the register side stall the bus with wait states. A word moves on each rising edge where the initiator-ready and target-ready lines are both low. The block asks the initiator to finish when a burst reaches the last doubleword of the addressed space. It drives an even parity bit for the data it puts on the bus, one clock late.

Top module: `ppb_target`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, claim_n, srdy_n and halt_n are high and bus_oe, par_oe, lcl_wr and lcl_rd are low. A reset in the middle of a cycle drops the claim.
- R2: A command code other than 4'b0010 (I/O read), 4'b0011 (I/O write), 4'b1010 (configuration read) or 4'b1011 (configuration write) is never claimed. claim_n stays high and no local strobe or bus drive follows. Bit 0 of a claimed code selects write (1) or read (0).
- R3: An I/O command is claimed only when address bits 31:IO_SPAN_LOG2 equal io_win. claim_n then goes low in the cycle after the address phase.
- R4: A configuration command is claimed only when cfg_sel is high in the address phase, address bits 1:0 are 00 and address bits 10:8 (function number) are 000.
- R5: In a claimed data phase srdy_n equals the inverse of lcl_ready. A word moves, with exactly one lcl_wr or lcl_rd pulse, only in a cycle where mrdy_n and srdy_n are both low.
- R6: On a write transfer lcl_wdata equals bus_d_in and lcl_be equals the bitwise inverse of cmd_be_n.
- R7: During every data phase of a claimed read bus_oe is high and bus_d_out equals lcl_rdata. bus_oe is low at all other times.
- R8: The first lcl_addr is the doubleword-aligned offset: {addr[7:2],00} for configuration, or address bits IO_SPAN_LOG2-1:2 followed by 00 for I/O. It rises by 4 per transfer and wraps inside a 256-byte or 2^IO_SPAN_LOG2-byte space. lcl_cfg is 1 for configuration.
- R9: halt_n is low exactly during data phases whose doubleword is the last one of its space (the next offset would wrap to 0).
- R10: A transfer with cyc_n high ends the cycle. claim_n and srdy_n are high in the next cycle.
- R11: par_oe equals bus_oe one cycle earlier. When it is high, par_out equals the XOR of bus_d_out and cmd_be_n of that earlier cycle, so the 37 bits hold an even count of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_n | input | 1 | Cycle start / more-phases line, active low |
| mrdy_n | input | 1 | Initiator ready, active low |
| cfg_sel | input | 1 | Configuration select, sampled in the address phase |
| bus_d_in | input | 32 | Address/data lines as seen by the target |
| cmd_be_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| io_win | input | 32-IO_SPAN_LOG2 | Upper address bits of the I/O window |
| bus_d_out | output | 32 | Read data driven onto the address/data lines |
| bus_oe | output | 1 | Drive enable for bus_d_out |
| par_out | output | 1 | Even parity bit |
| par_oe | output | 1 | Drive enable for par_out |
| claim_n | output | 1 | Device claim, active low |
| srdy_n | output | 1 | Target ready, active low |
| halt_n | output | 1 | Request to end the burst, active low |
| lcl_addr | output | 8 | Local doubleword-aligned byte offset |
| lcl_cfg | output | 1 | Local access is to configuration space |
| lcl_wr | output | 1 | Local write strobe |
| lcl_rd | output | 1 | Local read strobe |
| lcl_be | output | 4 | Local byte enables, active high |
| lcl_wdata | output | 32 | Local write data |
| lcl_rdata | input | 32 | Local read data |
| lcl_ready | input | 1 | Local side ready; low inserts wait states |

## Verification
The bench aims at the decode edges. These are I/O addresses one byte below and at the first byte past the window, a configuration access with cfg_sel low, with a non-zero function number or with non-zero low address bits, and memory and interrupt codes that share low bits with claimed ones. A decoder that compared too few bits would claim the foreign cycle, and the bench would see a claim and a local strobe. Bursts that run into the last doubleword of either space check that halt_n appears on that phase alone and that the offset wraps to 0 rather than running into the next space. Wait states from the local side must hold srdy_n high with no strobe. The parity bit, which lags its data by a cycle, is checked in each cycle of a read, including the cycle after the final word.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  localparam int BUS_W = 32;
  localparam int CBE_W = 4;
  localparam int OFF_W = 8;

  localparam logic [CBE_W-1:0] CMD_IO_RD  = 4'b0010;
  localparam logic [CBE_W-1:0] CMD_IO_WR  = 4'b0011;
  localparam logic [CBE_W-1:0] CMD_CFG_RD = 4'b1010;
  localparam logic [CBE_W-1:0] CMD_CFG_WR = 4'b1011;

  typedef enum logic {PH_IDLE, PH_DATA} phase_e;

  typedef struct packed {
    logic             is_cfg;
    logic             is_wr;
    logic [OFF_W-1:0] off;
  } claim_t;

  function automatic logic cmd_is_io(input logic [CBE_W-1:0] cmd);
    return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
  endfunction

  function automatic logic cmd_is_cfg(input logic [CBE_W-1:0] cmd);
    return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  endfunction

  function automatic logic even_par(input logic [BUS_W-1:0] d,
                                    input logic [CBE_W-1:0] c);
    return ^{d, c};
  endfunction

  function automatic logic [OFF_W-1:0] dword_step(input logic [OFF_W-1:0] off,
                                                  input logic [OFF_W-1:0] mask);
    return (off + OFF_W'(4)) & mask;
  endfunction

endpackage

// File: rtl/ppb_decode.sv
module ppb_decode
  import ppb_pkg::*;
#(
  parameter int IO_SPAN_LOG2 = 6
) (
  input  logic [BUS_W-1:0]        addr,
  input  logic [CBE_W-1:0]        cmd,
  input  logic                    cfg_sel,
  input  logic [31-IO_SPAN_LOG2:0] io_win,
  output logic                    hit,
  output claim_t                  info
);

  logic io_hit;
  logic cfg_hit;
  logic [OFF_W-1:0] io_off;
  logic [OFF_W-1:0] cfg_off;

  always_comb begin
    io_off = '0;
    io_off[IO_SPAN_LOG2-1:2] = addr[IO_SPAN_LOG2-1:2];
    cfg_off = {addr[7:2], 2'b00};
    io_hit  = cmd_is_io(cmd) && (addr[BUS_W-1:IO_SPAN_LOG2] == io_win);
    cfg_hit = cmd_is_cfg(cmd) && cfg_sel && (addr[1:0] == 2'b00)
              && (addr[10:8] == 3'b000);
    hit         = io_hit || cfg_hit;
    info.is_cfg = cmd[3];
    info.is_wr  = cmd[0];
    info.off    = cmd[3] ? cfg_off : io_off;
  end

endmodule

// File: rtl/ppb_phase.sv
module ppb_phase
  import ppb_pkg::*;
#(
  parameter int IO_SPAN_LOG2 = 6
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_n,
  input  logic   mrdy_n,
  input  logic   lcl_ready,
  input  logic   hit,
  input  claim_t info,
  output logic   addr_phase,
  output logic   in_data,
  output logic   xfer,
  output logic   last_dword,
  output claim_t cur
);

  localparam int IO_BYTES = 1 << IO_SPAN_LOG2;
  localparam logic [OFF_W-1:0] IO_MASK  = OFF_W'(IO_BYTES - 1);
  localparam logic [OFF_W-1:0] CFG_MASK = '1;

  phase_e state;
  logic   cyc_q;
  logic [OFF_W-1:0] mask;
  logic [OFF_W-1:0] next_off;

  assign in_data    = (state == PH_DATA);
  assign addr_phase = (state == PH_IDLE) && !cyc_n && cyc_q;
  assign xfer       = in_data && !mrdy_n && lcl_ready;
  assign mask       = cur.is_cfg ? CFG_MASK : IO_MASK;
  assign next_off   = dword_step(cur.off, mask);
  assign last_dword = in_data && (next_off == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      cyc_q <= 1'b1;
      cur   <= '0;
    end else begin
      cyc_q <= cyc_n;
      if (addr_phase && hit) begin
        state <= PH_DATA;
        cur   <= info;
      end else if (xfer) begin
        cur.off <= next_off;
        if (cyc_n) state <= PH_IDLE;
      end
    end
  end

endmodule

// File: rtl/ppb_parity.sv
module ppb_parity
  import ppb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] drv_data,
  input  logic [CBE_W-1:0] drv_cbe,
  input  logic             drv_en,
  output logic             par,
  output logic             par_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par    <= 1'b0;
      par_en <= 1'b0;
    end else begin
      par    <= drv_en ? even_par(drv_data, drv_cbe) : 1'b0;
      par_en <= drv_en;
    end
  end

endmodule

// File: rtl/ppb_target.sv
module ppb_target
  import ppb_pkg::*;
#(
  parameter int IO_SPAN_LOG2 = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cyc_n,
  input  logic                     mrdy_n,
  input  logic                     cfg_sel,
  input  logic [31:0]              bus_d_in,
  input  logic [3:0]               cmd_be_n,
  input  logic [31-IO_SPAN_LOG2:0] io_win,
  output logic [31:0]              bus_d_out,
  output logic                     bus_oe,
  output logic                     par_out,
  output logic                     par_oe,
  output logic                     claim_n,
  output logic                     srdy_n,
  output logic                     halt_n,
  output logic [7:0]               lcl_addr,
  output logic                     lcl_cfg,
  output logic                     lcl_wr,
  output logic                     lcl_rd,
  output logic [3:0]               lcl_be,
  output logic [31:0]              lcl_wdata,
  input  logic [31:0]              lcl_rdata,
  input  logic                     lcl_ready
);

  logic   dec_hit;
  claim_t dec_info;
  logic   addr_phase;
  logic   in_data;
  logic   xfer;
  logic   last_dword;
  claim_t cur;

  ppb_decode #(.IO_SPAN_LOG2(IO_SPAN_LOG2)) i_decode (
    .addr    (bus_d_in),
    .cmd     (cmd_be_n),
    .cfg_sel (cfg_sel),
    .io_win  (io_win),
    .hit     (dec_hit),
    .info    (dec_info)
  );

  ppb_phase #(.IO_SPAN_LOG2(IO_SPAN_LOG2)) i_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_n      (cyc_n),
    .mrdy_n     (mrdy_n),
    .lcl_ready  (lcl_ready),
    .hit        (dec_hit),
    .info       (dec_info),
    .addr_phase (addr_phase),
    .in_data    (in_data),
    .xfer       (xfer),
    .last_dword (last_dword),
    .cur        (cur)
  );

  assign claim_n   = !in_data;
  assign srdy_n    = !(in_data && lcl_ready);
  assign halt_n    = !last_dword;
  assign bus_oe    = in_data && !cur.is_wr;
  assign bus_d_out = bus_oe ? lcl_rdata : '0;
  assign lcl_addr  = cur.off;
  assign lcl_cfg   = cur.is_cfg;
  assign lcl_wr    = xfer && cur.is_wr;
  assign lcl_rd    = xfer && !cur.is_wr;
  assign lcl_be    = ~cmd_be_n;
  assign lcl_wdata = bus_d_in;

  ppb_parity i_parity (
    .clk      (clk),
    .rst_n    (rst_n),
    .drv_data (bus_d_out),
    .drv_cbe  (cmd_be_n),
    .drv_en   (bus_oe),
    .par      (par_out),
    .par_en   (par_oe)
  );

endmodule

// File: rtl/ppb_target_chk.sv
module ppb_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cyc_n,
  input logic        mrdy_n,
  input logic [3:0]  cmd_be_n,
  input logic [31:0] bus_d_out,
  input logic        bus_oe,
  input logic        par_out,
  input logic        par_oe,
  input logic        claim_n,
  input logic        srdy_n,
  input logic        halt_n,
  input logic [7:0]  lcl_addr,
  input logic        lcl_wr,
  input logic        lcl_rd
);

  // R5
  strobe_needs_both_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lcl_wr || lcl_rd) |-> (!mrdy_n && !srdy_n));

  // R5
  ready_only_when_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !srdy_n |-> !claim_n);

  // R3
  claim_follows_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(claim_n) |-> $past(!cyc_n));

  // R10
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_n && cyc_n && !mrdy_n && !srdy_n) |=> (claim_n && srdy_n));

  // R7
  drive_only_when_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !claim_n);

  // R9
  halt_only_when_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_n |-> !claim_n);

  // R8
  offset_holds_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_n && !lcl_wr && !lcl_rd) |=> $stable(lcl_addr));

  // R11
  parity_enable_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (par_oe == $past(bus_oe)));

  // R11
  parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_oe) |-> (par_out == ^{$past(bus_d_out), $past(cmd_be_n)}));

endmodule

bind ppb_target ppb_target_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_n     (cyc_n),
  .mrdy_n    (mrdy_n),
  .cmd_be_n  (cmd_be_n),
  .bus_d_out (bus_d_out),
  .bus_oe    (bus_oe),
  .par_out   (par_out),
  .par_oe    (par_oe),
  .claim_n   (claim_n),
  .srdy_n    (srdy_n),
  .halt_n    (halt_n),
  .lcl_addr  (lcl_addr),
  .lcl_wr    (lcl_wr),
  .lcl_rd    (lcl_rd)
);

// File: tb/test_ppb_target.sv
`timescale 1ns/100ps
module test_ppb_target;

  localparam int IO_SPAN_LOG2 = 6;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic        sel;
    logic [2:0]  nph;
    logic [1:0]  waits;
    logic        hit;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'b0011, 32'h0000_C044, 1'b0, 3'd2, 2'd0, 1'b1},
    '{4'b0010, 32'h0000_C07C, 1'b0, 3'd1, 2'd0, 1'b1},
    '{4'b0011, 32'h0000_C080, 1'b0, 3'd1, 2'd0, 1'b0},
    '{4'b0010, 32'h0000_C03F, 1'b0, 3'd1, 2'd0, 1'b0},
    '{4'b1011, 32'h0000_0010, 1'b1, 3'd2, 2'd1, 1'b1},
    '{4'b1010, 32'h0000_00FC, 1'b1, 3'd2, 2'd0, 1'b1},
    '{4'b1010, 32'h0000_0010, 1'b0, 3'd1, 2'd0, 1'b0},
    '{4'b1011, 32'h0000_0104, 1'b1, 3'd1, 2'd0, 1'b0},
    '{4'b1011, 32'h0000_0006, 1'b1, 3'd1, 2'd0, 1'b0},
    '{4'b0111, 32'h0000_C044, 1'b0, 3'd1, 2'd0, 1'b0},
    '{4'b0110, 32'h0000_C040, 1'b0, 3'd1, 2'd0, 1'b0},
    '{4'b0000, 32'h0000_C040, 1'b1, 3'd1, 2'd0, 1'b0},
    '{4'b0011, 32'h0000_C047, 1'b0, 3'd3, 2'd2, 1'b1},
    '{4'b0010, 32'h0000_C078, 1'b0, 3'd3, 2'd1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_n = 1'b1;
  logic        mrdy_n = 1'b1;
  logic        cfg_sel = 1'b0;
  logic [31:0] bus_d_in = '0;
  logic [3:0]  cmd_be_n = 4'hF;
  logic [31-IO_SPAN_LOG2:0] io_win = 26'(32'h0000_C040 >> IO_SPAN_LOG2);
  logic [31:0] bus_d_out;
  logic        bus_oe, par_out, par_oe, claim_n, srdy_n, halt_n;
  logic [7:0]  lcl_addr;
  logic        lcl_cfg, lcl_wr, lcl_rd;
  logic [3:0]  lcl_be;
  logic [31:0] lcl_wdata, lcl_rdata;
  logic        lcl_ready = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  logic prev_oe = 1'b0;
  logic prev_par = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rmodel(input logic [7:0] off);
    return {8'hA5, off, ~off, 8'h3C};
  endfunction

  assign lcl_rdata = rmodel(lcl_addr);

  ppb_target #(.IO_SPAN_LOG2(IO_SPAN_LOG2)) i_ppb_target (
    .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .mrdy_n(mrdy_n),
    .cfg_sel(cfg_sel), .bus_d_in(bus_d_in), .cmd_be_n(cmd_be_n),
    .io_win(io_win), .bus_d_out(bus_d_out), .bus_oe(bus_oe),
    .par_out(par_out), .par_oe(par_oe), .claim_n(claim_n),
    .srdy_n(srdy_n), .halt_n(halt_n), .lcl_addr(lcl_addr),
    .lcl_cfg(lcl_cfg), .lcl_wr(lcl_wr), .lcl_rd(lcl_rd),
    .lcl_be(lcl_be), .lcl_wdata(lcl_wdata), .lcl_rdata(lcl_rdata),
    .lcl_ready(lcl_ready)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R11: parity of the previous cycle and its enable
  task automatic par_track(input bit oe_now, input logic [31:0] d_now);
    check(par_oe == prev_oe, "R11 par_oe", 32'(par_oe), 32'(prev_oe));
    if (prev_oe)
      check(par_out == prev_par, "R11 par_out", 32'(par_out), 32'(prev_par));
    prev_oe  = oe_now;
    prev_par = ^{d_now, cmd_be_n};
  endtask

  task automatic run_bus(input vec_t v);
    logic [7:0] eoff;
    logic [7:0] emask;
    logic [31:0] wd;
    logic [3:0] be;
    string dreq;
    bit rd;
    emask = v.cmd[3] ? 8'hFF : 8'h3F;
    eoff  = v.cmd[3] ? {v.addr[7:2], 2'b00} : {2'b00, v.addr[5:2], 2'b00};
    rd    = !v.cmd[0];
    if (!((v.cmd[3:1] == 3'b001) || (v.cmd[3:1] == 3'b101))) dreq = "R2";
    else if (v.cmd[3]) dreq = "R4";
    else dreq = "R3";
    @(posedge clk); #1;
    cyc_n = 1'b0; bus_d_in = v.addr; cmd_be_n = v.cmd; cfg_sel = v.sel;
    mrdy_n = 1'b1; lcl_ready = 1'b1;
    @(posedge clk); #1;
    cfg_sel = 1'b0;
    if (!v.hit) begin
      mrdy_n = 1'b0; cyc_n = 1'b1; bus_d_in = 32'h0BAD_F00D; cmd_be_n = 4'h0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(claim_n && !lcl_wr && !lcl_rd && !bus_oe, {dreq, " ignored"},
              {28'h0, claim_n, lcl_wr, lcl_rd, bus_oe}, 32'h8);
        @(posedge clk); #1;
      end
      mrdy_n = 1'b1; cmd_be_n = 4'hF;
    end else begin
      for (int p = 0; p < int'(v.nph); p++) begin
        wd = {16'h1234, 8'(p), v.addr[7:0]};
        be = 4'(p * 5) ^ 4'b0110;
        cyc_n = (p == int'(v.nph) - 1); mrdy_n = 1'b0;
        bus_d_in = wd; cmd_be_n = be; lcl_ready = (v.waits == 2'd0);
        for (int w = 0; w < int'(v.waits); w++) begin
          @(negedge clk);
          check(srdy_n && !lcl_wr && !lcl_rd, "R5 wait state",
                {29'h0, srdy_n, lcl_wr, lcl_rd}, 32'h4);
          check(lcl_addr == eoff, "R8 offset in wait", 32'(lcl_addr), 32'(eoff));
          par_track(rd, rmodel(eoff));
          @(posedge clk); #1;
          if (w == int'(v.waits) - 1) lcl_ready = 1'b1;
        end
        @(negedge clk);
        check(!claim_n, {dreq, " claim"}, 32'(claim_n), 32'h0);
        check(!srdy_n, "R5 ready", 32'(srdy_n), 32'h0);
        check(lcl_addr == eoff && lcl_cfg == v.cmd[3], "R8 offset",
              {23'h0, lcl_cfg, lcl_addr}, {23'h0, v.cmd[3], eoff});
        check(halt_n == (((eoff + 8'd4) & emask) != 8'h00), "R9 halt",
              32'(halt_n), 32'(((eoff + 8'd4) & emask) != 8'h00));
        if (!rd) begin
          check(lcl_wr && !lcl_rd, "R5 write strobe", {30'h0, lcl_wr, lcl_rd}, 32'h2);
          check(lcl_wdata == wd && lcl_be == ~be, "R6 write data",
                lcl_wdata ^ {28'h0, lcl_be}, wd ^ {28'h0, ~be});
          check(!bus_oe, "R7 no drive on write", 32'(bus_oe), 32'h0);
        end else begin
          check(lcl_rd && !lcl_wr, "R5 read strobe", {30'h0, lcl_wr, lcl_rd}, 32'h1);
          check(bus_oe && bus_d_out == rmodel(eoff), "R7 read data",
                bus_d_out, rmodel(eoff));
        end
        par_track(rd, rmodel(eoff));
        @(posedge clk); #1;
        eoff = (eoff + 8'd4) & emask;
      end
      mrdy_n = 1'b1; cyc_n = 1'b1; bus_d_in = '0; cmd_be_n = 4'hF;
      @(negedge clk);
      check(claim_n && srdy_n && halt_n, "R10 release",
            {29'h0, claim_n, srdy_n, halt_n}, 32'h7);
      check(!bus_oe, "R7 drive off", 32'(bus_oe), 32'h0);
      par_track(1'b0, 32'h0);
      @(posedge clk); #1;
      @(negedge clk);
      par_track(1'b0, 32'h0);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 2000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: reset state
    check(claim_n && srdy_n && halt_n && !bus_oe && !par_oe && !lcl_wr && !lcl_rd,
          "R1 in reset", {25'h0, claim_n, srdy_n, halt_n, bus_oe, par_oe, lcl_wr, lcl_rd},
          32'h70);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(claim_n && srdy_n && halt_n && !bus_oe && !par_oe, "R1 after reset",
          {27'h0, claim_n, srdy_n, halt_n, bus_oe, par_oe}, 32'h1C);

    for (int i = 0; i < NV; i++) run_bus(VECS[i]);

    // R1: reset in the middle of a claimed cycle
    @(posedge clk); #1;
    cyc_n = 1'b0; bus_d_in = 32'h0000_C050; cmd_be_n = 4'b0011;
    @(posedge clk); #1;
    lcl_ready = 1'b0; mrdy_n = 1'b0; bus_d_in = 32'h1; cmd_be_n = 4'h0;
    @(negedge clk);
    check(!claim_n, "R3 claim before reset", 32'(claim_n), 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b0;
    @(negedge clk);
    check(claim_n && srdy_n && !lcl_wr, "R1 reset mid-cycle",
          {29'h0, claim_n, srdy_n, lcl_wr}, 32'h6);
    @(posedge clk); #1;
    cyc_n = 1'b1; mrdy_n = 1'b1; cmd_be_n = 4'hF; lcl_ready = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check(claim_n && srdy_n, "R1 idle after reset", {30'h0, claim_n, srdy_n}, 32'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule